// File: doc/BRIEF.md
# Masked Barrier Synchronization Unit

This block lets a set of processing nodes meet at software barriers. Each node keeps a one-bit progress phase that flips every time the node enters a barrier. The phase is sent over a shared broadcast fabric, so every node holds a registered copy of every other node's phase. A node counts as done only when two things are true for every member of its group. First, the member has reached the same phase. Second, the member has reported back that it received the matching phase from all of its own group members. A completion pulse is then raised on each node of the group, and each node leaves its waiting state.

Each node has its own row of mask bits, with one bit per node. The row picks the nodes that belong to that node's group. Nodes outside the mask are ignored, whatever their phase. Because of this, separate groups can run separate barriers at the same time without affecting one another. Software may rewrite a node's mask row only while that node is not waiting at a barrier.

The fabric latency is modelled as fixed register stages: broadcast, receive, acknowledge and acknowledge-receive. A completion therefore shows up a fixed number of cycles after the last member arrives. The number of nodes is a parameter `N`, with a default of 8.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset, every phase bit is 0, no node is waiting, `syncDone` is all zero, and every mask row reads all ones, so every node is in one group.
- R2: An `arriveReq` bit sampled while that node is idle flips the node's phase and sets its `waitOut` bit at the same edge. An `arriveReq` bit sampled while the node is already waiting is ignored: neither its phase nor its completion is affected.
- R3: No node of a group raises `syncDone` while any member of its mask has not yet entered the current barrier.
- R4: When the last member's arrival is captured at clock edge E, every member's `syncDone` bit is high for exactly one cycle, starting at edge E+5. At that same edge the member's `waitOut` bit falls.
- R5: A node whose bit is clear in a waiting node's mask row is ignored by that node's barrier, even if its phase differs.
- R6: Disjoint groups complete independently. Each group's completion is timed only by its own last arrival.
- R7: Mask row i occupies bits [i*N +: N] of `maskWrData` and `maskOut`, and bit j of the row means node j takes part. A write with `maskWrEn[i]` set takes effect at the next edge if node i is idle. The write is ignored if node i is waiting.
- R8: Successive barriers on the same group do not get mixed up. A node may re-arrive during the cycle in which its `syncDone` is high, and the next barrier then completes with the R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arriveReq | input | N | Per-node barrier entry request |
| maskWrEn | input | N | Per-node mask row write enable |
| maskWrData | input | N*N | New mask rows, row i at [i*N +: N] |
| syncDone | output | N | Per-node one-cycle completion pulse |
| waitOut | output | N | Per-node waiting-at-barrier flag |
| phaseOut | output | N | Per-node current progress phase |
| maskOut | output | N*N | Current mask rows, row i at [i*N +: N] |

## Verification
The bench builds the unit with N = 4. At that size every mask row can be read in a single 16-bit word, and the whole node set can be split into two disjoint pairs. The cycle-by-cycle table covers full-group barriers, a duplicate arrival during a wait, and an immediate re-arrival on the completion cycle. The directed part covers the paired groups finishing at different edges, idle non-members with a differing phase, and a mask write rejected during a wait and accepted afterwards.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Per-node strobes issued by the control toward the datapath.
  typedef struct packed {
    logic enter;     // flip the phase: the node joins a barrier
    logic maskLoad;  // capture a new mask row
  } nodeStrobe_t;
endpackage

// File: rtl/barrier_fabric.sv
module barrier_fabric
  import barrier_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nodeStrobe_t [N-1:0]  strobe,
  input  logic [N*N-1:0]       maskWrData,
  output logic [N-1:0]         phaseOut,
  output logic [N*N-1:0]       maskOut,
  output logic [N-1:0]         groupReady
);
  logic [N-1:0] phase;
  logic [N-1:0] bcastPhase;   // broadcast stage of every phase
  logic [N-1:0] ackOk;        // broadcast stage of every node's match flag
  logic [N-1:0] ackPh;        // phase that the match flag refers to
  logic [N-1:0] matchNow;
  logic [N-1:0] maskRow  [N];
  logic [N-1:0] rxPhase  [N]; // node i's received copy of all phases
  logic [N-1:0] ackRxOk  [N]; // node i's received copy of all acks
  logic [N-1:0] ackRxPh  [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= '0;
      bcastPhase <= '0;
      ackOk      <= '0;
      ackPh      <= '0;
      for (int i = 0; i < N; i++) begin
        maskRow[i] <= '1;
        rxPhase[i] <= '0;
        ackRxOk[i] <= '0;
        ackRxPh[i] <= '0;
      end
    end else begin
      bcastPhase <= phase;
      ackOk      <= matchNow;
      ackPh      <= phase;
      for (int i = 0; i < N; i++) begin
        if (strobe[i].enter)    phase[i]   <= ~phase[i];
        if (strobe[i].maskLoad) maskRow[i] <= maskWrData[i*N +: N];
        rxPhase[i] <= bcastPhase;
        ackRxOk[i] <= ackOk;
        ackRxPh[i] <= ackPh;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_node
    logic [N-1:0] samePhase;
    logic [N-1:0] sameAck;
    assign samePhase   = ~(rxPhase[g] ^ {N{phase[g]}});
    assign sameAck     = ackRxOk[g] & ~(ackRxPh[g] ^ {N{phase[g]}});
    assign matchNow[g] = &(~maskRow[g] | samePhase);
    assign groupReady[g] = &(~maskRow[g] | (samePhase & sameAck));
    assign maskOut[g*N +: N] = maskRow[g];
  end

  assign phaseOut = phase;
endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         arriveReq,
  input  logic [N-1:0]         maskWrEn,
  input  logic [N-1:0]         groupReady,
  output nodeStrobe_t [N-1:0]  strobe,
  output logic [N-1:0]         waitOut,
  output logic [N-1:0]         syncDone
);
  logic [N-1:0] waiting;
  logic [N-1:0] enterVec;
  logic [N-1:0] doneNext;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      enterVec[i]        = arriveReq[i] & ~waiting[i];
      strobe[i].enter    = enterVec[i];
      strobe[i].maskLoad = maskWrEn[i] & ~waiting[i];
    end
  end

  assign doneNext = waiting & groupReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waiting  <= '0;
      syncDone <= '0;
    end else begin
      waiting  <= (waiting & ~doneNext) | enterVec;
      syncDone <= doneNext;
    end
  end

  assign waitOut = waiting;
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
  import barrier_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         arriveReq,
  input  logic [N-1:0]         maskWrEn,
  input  logic [N*N-1:0]       maskWrData,
  output logic [N-1:0]         syncDone,
  output logic [N-1:0]         waitOut,
  output logic [N-1:0]         phaseOut,
  output logic [N*N-1:0]       maskOut
);
  localparam int MASK_W = N * N;

  nodeStrobe_t [N-1:0] strobe;
  logic [N-1:0]        groupReady;
  logic [MASK_W-1:0]   maskBus;

  barrier_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arriveReq  (arriveReq),
    .maskWrEn   (maskWrEn),
    .groupReady (groupReady),
    .strobe     (strobe),
    .waitOut    (waitOut),
    .syncDone   (syncDone)
  );

  barrier_fabric #(.N(N)) u_fabric (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .maskWrData (maskWrData),
    .phaseOut   (phaseOut),
    .maskOut    (maskBus),
    .groupReady (groupReady)
  );

  assign maskOut = maskBus;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic [N-1:0]   syncDone,
  input logic [N-1:0]   waitOut,
  input logic [N-1:0]   phaseOut,
  input logic [N*N-1:0] maskOut
);
  for (genvar g = 0; g < N; g++) begin : g_chk
    // R4: a completion ends a wait that was in progress
    a_r4_done_ends_wait: assert property (@(posedge clk) disable iff (!rstN)
      syncDone[g] |-> (!waitOut[g] && $past(waitOut[g])));
    // R4: the completion pulse is one cycle wide
    a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
      syncDone[g] |=> !syncDone[g]);
    // R2: entering a barrier flips the phase
    a_r2_entry_flips_phase: assert property (@(posedge clk) disable iff (!rstN)
      $rose(waitOut[g]) |-> (phaseOut[g] != $past(phaseOut[g])));
    // R2: repeated arrivals during a wait leave the phase alone
    a_r2_phase_held_in_wait: assert property (@(posedge clk) disable iff (!rstN)
      (waitOut[g] && $past(waitOut[g])) |-> $stable(phaseOut[g]));
    // R7: mask row frozen while the node waits
    a_r7_mask_frozen_in_wait: assert property (@(posedge clk) disable iff (!rstN)
      (waitOut[g] && $past(waitOut[g])) |-> $stable(maskOut[g*N +: N]));
  end
endmodule

bind barrier_sync_unit barrier_sync_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .syncDone (syncDone),
  .waitOut  (waitOut),
  .phaseOut (phaseOut),
  .maskOut  (maskOut)
);

// File: tb/barrier_sync_unit_tb.sv
module barrier_sync_unit_tb;
  localparam int NODES = 4;
  localparam int ROWS  = 21;
  // Each entry: {arriveReq, expected waitOut, expected syncDone} after the edge.
  localparam logic [11:0] VEC [ROWS] = '{
    12'h110, 12'h230, 12'hCF0, 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0,
    12'h00F, 12'h000, 12'hFF0, 12'h5F0, 12'h0F0, 12'h0F0, 12'h0F0,
    12'h00F, 12'hFF0, 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0, 12'h00F
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NODES-1:0] arriveReq = '0;
  logic [NODES-1:0] maskWrEn = '0;
  logic [NODES*NODES-1:0] maskWrData = '0;
  logic [NODES-1:0] syncDone, waitOut, phaseOut;
  logic [NODES*NODES-1:0] maskOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  barrier_sync_unit #(.N(NODES)) u_dut (
    .clk(clk), .rstN(rstN), .arriveReq(arriveReq), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .syncDone(syncDone), .waitOut(waitOut),
    .phaseOut(phaseOut), .maskOut(maskOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] arr, input logic [3:0] we, input logic [15:0] wd);
    arriveReq  = arr;
    maskWrEn   = we;
    maskWrData = wd;
    @(posedge clk);
    #1;
    arriveReq = '0;
    maskWrEn  = '0;
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog (R1..all): actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 done",  16'(syncDone), 16'h0);
    check("R1 wait",  16'(waitOut),  16'h0);
    check("R1 phase", 16'(phaseOut), 16'h0);
    check("R1 mask",  maskOut,       16'hFFFF);

    // R3 R4 R2 R8: cycle-by-cycle vectors, full group
    for (int r = 0; r < ROWS; r++) begin
      step(VEC[r][11:8], 4'h0, 16'h0);
      check($sformatf("R3 R4 row %0d wait", r), 16'(waitOut),  16'(VEC[r][7:4]));
      check($sformatf("R4 R8 row %0d done", r), 16'(syncDone), 16'(VEC[r][3:0]));
    end
    check("R2 R8 phase after three barriers", 16'(phaseOut), 16'hF);

    // R7: idle write, two disjoint pairs {0,1} and {2,3}
    step(4'h0, 4'hF, 16'hCC33);
    check("R7 idle write", maskOut, 16'hCC33);

    // R6: groups finish independently
    step(4'b0101, 4'h0, 16'h0);
    check("R6 wait first", 16'(waitOut), 16'h5);
    step(4'b0010, 4'h0, 16'h0);   // group A last arrival, edge E
    step(4'b0000, 4'h0, 16'h0);
    step(4'b1000, 4'h0, 16'h0);   // group B last arrival
    step(4'b0000, 4'h0, 16'h0);
    step(4'b0000, 4'h0, 16'h0);
    check("R6 A not early", 16'(syncDone), 16'h0);
    step(4'b0000, 4'h0, 16'h0);   // E+5 for group A
    check("R6 A done", 16'(syncDone), 16'h3);
    check("R6 B still waiting", 16'(waitOut), 16'hC);
    step(4'b0000, 4'h0, 16'h0);
    check("R6 B not early", 16'(syncDone), 16'h0);
    step(4'b0000, 4'h0, 16'h0);
    check("R6 B done", 16'(syncDone), 16'hC);
    check("R6 all idle", 16'(waitOut), 16'h0);

    // R5: nodes 2,3 idle with a differing phase are outside the pair's mask
    step(4'b0011, 4'h0, 16'h0);
    check("R5 phase differs", 16'(phaseOut), 16'h3);
    for (int k = 0; k < 4; k++) step(4'h0, 4'h0, 16'h0);
    check("R5 not early", 16'(syncDone), 16'h0);
    step(4'h0, 4'h0, 16'h0);
    check("R5 done despite outsiders", 16'(syncDone), 16'h3);

    // R7: write during a wait is ignored
    step(4'b0001, 4'h0, 16'h0);
    step(4'h0, 4'b0001, 16'hCC31);
    check("R7 write in wait ignored", maskOut, 16'hCC33);
    check("R7 node still waiting", 16'(waitOut), 16'h1);
    step(4'b0010, 4'h0, 16'h0);
    for (int k = 0; k < 4; k++) step(4'h0, 4'h0, 16'h0);
    check("R7 pair not early", 16'(syncDone), 16'h0);
    step(4'h0, 4'h0, 16'h0);
    check("R7 pair done", 16'(syncDone), 16'h3);
    step(4'h0, 4'b0001, 16'hCC31);
    check("R7 write after wait", maskOut, 16'hCC31);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule